// File: doc/BRIEF.md
# Framed serial word receiver

This block takes one single-ended serial line that rests high and recovers 32-bit words from it. Each bit lasts exactly four clock cycles and is NRZ coded. A frame opens with a two-bit start pattern: one bit low, then one bit high. Thirty-two data bits follow, then an even parity bit, then a stop bit that must be high. The line enters through a two-flop synchroniser. The receiver aligns its bit timing to the first low sample it sees while idle, and it reads each later bit once, in the middle of its period.

The receiver checks every frame. It flags a start pattern that breaks down, a parity mismatch or a low stop bit, and it never presents a damaged word as valid. A saturating per-channel error counter rises on each rejected frame and clears on each good one. When the counter reaches a programmable limit, the channel is marked disabled and its valid strobe is held off. It stays that way until software pulses the re-enable input. This lets a receiver on an unconnected or noisy input stop feeding garbage words into shared storage.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, `word_valid`, `parity_err`, `stop_err`, `false_start` and `chan_disabled` are all 0.
- R2: While idle, the first low sample starts a frame. All four samples of the first start bit must be low and all four samples of the second start bit must be high. Any mismatching sample raises `false_start` for one cycle and returns the receiver to idle without a word.
- R3: Each bit after the start pattern is read once, at sample index 2 of its four-cycle period. Index 0 is the cycle in which the opening low level is first seen. The levels at indices 0, 1 and 3 have no effect on the received word.
- R4: Data bits arrive least significant bit first. A good frame raises `word_valid` for exactly one cycle, with the 32 received bits on `word_data`.
- R5: The parity bit makes the total number of ones over the 32 data bits and the parity bit even. On a mismatch, `parity_err` pulses and `word_valid` stays 0.
- R6: A stop bit read as low pulses `stop_err`, and `word_valid` stays 0.
- R7: After reading the stop bit, the receiver goes back to idle. A new frame that begins right after the stop bit, with no extra idle time, is received.
- R8: The error counter saturates. It increments on each frame that ends with a parity error, a stop error or a false start, and it clears on each good frame. When the updated count reaches a nonzero `err_limit`, `chan_disabled` rises one cycle after the rejecting flag. An `err_limit` of 0 never disables the channel.
- R9: While `chan_disabled` is 1, `word_valid` stays 0 and the error flags are still reported. A one-cycle pulse on `chan_reenable` clears both the counter and `chan_disabled`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Serial line, asynchronous to clk, idles high |
| err_limit | input | 4 | Rejected-frame count that disables the channel; 0 turns disabling off |
| chan_reenable | input | 1 | Clears the error counter and the disabled state |
| word_valid | output | 1 | One-cycle strobe for a good frame on an enabled channel |
| word_data | output | 32 | Last received data word |
| parity_err | output | 1 | One-cycle pulse: parity mismatch |
| stop_err | output | 1 | One-cycle pulse: stop bit low |
| false_start | output | 1 | One-cycle pulse: start pattern broke down |
| chan_disabled | output | 1 | Channel disabled by the error counter |

## Verification
The hardest case to reach from the ports is proving that only the middle sample of each bit counts. The line must hold a wrong level for three of the four cycles of every data bit, with the one correct cycle exactly where the receiver's timing puts index 2. The bench reaches this by driving the line on the falling clock edge with a fixed four-cycle cadence that starts at the opening low level. Because the synchroniser adds the same delay to every transition, the bench's cycle count inside each bit matches the receiver's sample index. The disable path is also reached only through sequences of rejected frames: counts interleaved with good frames, false starts that count as rejects, and a limit of zero that must never trip.

// File: rtl/serial_rx_pkg.sv
// Package: shared types for the framed serial word receiver.
// Assumes nothing beyond IEEE 1800-2017 enums.
package serial_rx_pkg;

    // Receiver sequencing states, in frame order
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_START_LO = 3'd1,
        ST_START_HI = 3'd2,
        ST_DATA     = 3'd3,
        ST_PARITY   = 3'd4,
        ST_STOP     = 3'd5
    } rx_state_t;

endpackage

// File: rtl/line_sync.sv
// Module: line_sync
// Brings an asynchronous line into the clock domain through a chain of flops.
// Assumes STAGES >= 2. The chain resets high so that reset looks like an idle line.
module line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw line through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/frame_fsm.sv
// Module: frame_fsm
// Finds the start pattern, then reads the data, parity and stop bits of one
// frame. The result is given as one-cycle registered pulses.
// Assumes a synchronised line, SPB >= 2, SAMPLE_IDX < SPB and DATA_W >= 2.
module frame_fsm
    import serial_rx_pkg::*;
#(
    parameter int SPB        = 4,
    parameter int SAMPLE_IDX = 2,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_s,
    output logic              done_ok,
    output logic              done_par,
    output logic              done_stop,
    output logic              done_fs,
    output logic [DATA_W-1:0] data_out
);

    localparam int PH_W  = (SPB > 1) ? $clog2(SPB) : 1;
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(SPB - 1);
    localparam logic [PH_W-1:0]  PH_SMP   = PH_W'(SAMPLE_IDX);
    localparam logic [PH_W-1:0]  PH_ONE   = PH_W'(1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    rx_state_t         state_q;
    logic [PH_W-1:0]   phase_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] shift_q;
    logic              par_q;
    logic              par_bad;
    logic              at_last;
    logic              at_smp;

    // Decode the sample position and the parity check
    always_comb begin
        at_last = (phase_q == PH_LAST);
        at_smp  = (phase_q == PH_SMP);
        par_bad = ((^shift_q) ^ par_q);
    end

    // Step the frame sequence and register the per-frame result pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            phase_q   <= '0;
            bit_q     <= '0;
            shift_q   <= '0;
            par_q     <= 1'b0;
            done_ok   <= 1'b0;
            done_par  <= 1'b0;
            done_stop <= 1'b0;
            done_fs   <= 1'b0;
            data_out  <= '0;
        end else begin
            done_ok   <= 1'b0;
            done_par  <= 1'b0;
            done_stop <= 1'b0;
            done_fs   <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (!line_s) begin
                        state_q <= ST_START_LO;
                        phase_q <= PH_ONE;
                    end
                end
                ST_START_LO: begin
                    if (line_s) begin
                        done_fs <= 1'b1;
                        state_q <= ST_IDLE;
                        phase_q <= '0;
                    end else if (at_last) begin
                        state_q <= ST_START_HI;
                        phase_q <= '0;
                    end else begin
                        phase_q <= phase_q + PH_ONE;
                    end
                end
                ST_START_HI: begin
                    if (!line_s) begin
                        done_fs <= 1'b1;
                        state_q <= ST_IDLE;
                        phase_q <= '0;
                    end else if (at_last) begin
                        state_q <= ST_DATA;
                        phase_q <= '0;
                        bit_q   <= '0;
                    end else begin
                        phase_q <= phase_q + PH_ONE;
                    end
                end
                ST_DATA: begin
                    if (at_smp) begin
                        shift_q <= {line_s, shift_q[DATA_W-1:1]};
                    end
                    if (at_last) begin
                        phase_q <= '0;
                        if (bit_q == BIT_LAST) begin
                            state_q <= ST_PARITY;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end else begin
                        phase_q <= phase_q + PH_ONE;
                    end
                end
                ST_PARITY: begin
                    if (at_smp) begin
                        par_q <= line_s;
                    end
                    if (at_last) begin
                        state_q <= ST_STOP;
                        phase_q <= '0;
                    end else begin
                        phase_q <= phase_q + PH_ONE;
                    end
                end
                ST_STOP: begin
                    if (at_smp) begin
                        done_ok   <= !par_bad && line_s;
                        done_par  <= par_bad;
                        done_stop <= !line_s;
                        data_out  <= shift_q;
                        state_q   <= ST_IDLE;
                        phase_q   <= '0;
                    end else begin
                        phase_q <= phase_q + PH_ONE;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    phase_q <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/chan_health.sv
// Module: chan_health
// Counts rejected frames with a saturating counter and disables the channel
// at a programmable limit. Assumes the good and bad inputs are one-cycle
// pulses that never occur together. A limit of 0 turns disabling off.
module chan_health #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_good,
    input  logic             frame_bad,
    input  logic [CNT_W-1:0] limit,
    input  logic             reenable,
    output logic             disabled
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic             trip;
    logic             dis_q;

    // Next count: re-enable and good frames clear it, rejects saturate upward
    always_comb begin
        if (reenable || frame_good) begin
            cnt_next = '0;
        end else if (frame_bad && (cnt_q != CNT_MAX)) begin
            cnt_next = cnt_q + 1'b1;
        end else begin
            cnt_next = cnt_q;
        end
        trip = frame_bad && !reenable && (limit != '0) && (cnt_next >= limit);
    end

    // Hold the count and the sticky disable state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dis_q <= 1'b0;
        end else begin
            cnt_q <= cnt_next;
            dis_q <= reenable ? 1'b0 : (dis_q | trip);
        end
    end

    assign disabled = dis_q;

endmodule

// File: rtl/serial_frame_rx.sv
// Module: serial_frame_rx (top)
// Framed serial word receiver: synchroniser, frame sequencer and channel
// health tracker. Assumes a line that idles high and bits of exactly SPB cycles.
module serial_frame_rx #(
    parameter int SPB         = 4,
    parameter int SAMPLE_IDX  = 2,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    input  logic [CNT_W-1:0]  err_limit,
    input  logic              chan_reenable,
    output logic              word_valid,
    output logic [DATA_W-1:0] word_data,
    output logic              parity_err,
    output logic              stop_err,
    output logic              false_start,
    output logic              chan_disabled
);

    logic line_s;
    logic ok_p;
    logic par_p;
    logic stop_p;
    logic fs_p;
    logic bad_p;

    line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (line_in),
        .dout  (line_s)
    );

    frame_fsm #(
        .SPB        (SPB),
        .SAMPLE_IDX (SAMPLE_IDX),
        .DATA_W     (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_s    (line_s),
        .done_ok   (ok_p),
        .done_par  (par_p),
        .done_stop (stop_p),
        .done_fs   (fs_p),
        .data_out  (word_data)
    );

    // Any rejected frame feeds the health counter
    always_comb begin
        bad_p = par_p | stop_p | fs_p;
    end

    chan_health #(.CNT_W(CNT_W)) u_health (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_good (ok_p),
        .frame_bad  (bad_p),
        .limit      (err_limit),
        .reenable   (chan_reenable),
        .disabled   (chan_disabled)
    );

    // Present results; a disabled channel withholds its strobe
    always_comb begin
        word_valid  = ok_p & ~chan_disabled;
        parity_err  = par_p;
        stop_err    = stop_p;
        false_start = fs_p;
    end

endmodule

// File: rtl/serial_frame_rx_chk.sv
// Module: serial_frame_rx_chk
// Port-level properties of the receiver, bound to every instance of the top.
module serial_frame_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic chan_reenable,
    input logic word_valid,
    input logic parity_err,
    input logic stop_err,
    input logic false_start,
    input logic chan_disabled
);

    // R5
    valid_not_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> !parity_err);

    // R6
    valid_not_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> !stop_err);

    // R2
    valid_not_false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        false_start |-> !word_valid);

    // R4
    valid_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R9
    disabled_blocks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_disabled |-> !word_valid);

    // R9
    reenable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_reenable |=> !chan_disabled);

    // R8
    disable_after_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chan_disabled) |-> $past(parity_err || stop_err || false_start));

endmodule

bind serial_frame_rx serial_frame_rx_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .chan_reenable (chan_reenable),
    .word_valid    (word_valid),
    .parity_err    (parity_err),
    .stop_err      (stop_err),
    .false_start   (false_start),
    .chan_disabled (chan_disabled)
);

// File: tb/sim_serial_frame_rx.sv
// Bench for serial_frame_rx: a vector table of frames, then directed tests.
module sim_serial_frame_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_in = 1'b1;
    logic [3:0]  err_limit = 4'd0;
    logic        chan_reenable = 1'b0;
    logic        word_valid;
    logic [31:0] word_data;
    logic        parity_err;
    logic        stop_err;
    logic        false_start;
    logic        chan_disabled;

    int checks = 0;
    int errors = 0;

    // Sticky captures taken on the falling edge
    logic        cap_valid, cap_par, cap_stop, cap_fs;
    logic [31:0] cap_data;
    int          valid_cnt;

    always #2.5 clk = ~clk;

    serial_frame_rx u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_in       (line_in),
        .err_limit     (err_limit),
        .chan_reenable (chan_reenable),
        .word_valid    (word_valid),
        .word_data     (word_data),
        .parity_err    (parity_err),
        .stop_err      (stop_err),
        .false_start   (false_start),
        .chan_disabled (chan_disabled)
    );

    logic clr_req = 1'b0;

    // Capture pulses away from the active edge
    always @(negedge clk) begin
        if (clr_req) begin
            cap_valid <= 1'b0; cap_par <= 1'b0; cap_stop <= 1'b0; cap_fs <= 1'b0;
            cap_data  <= '0;   valid_cnt <= 0;
        end else begin
            if (word_valid) begin
                cap_valid <= 1'b1;
                cap_data  <= word_data;
                valid_cnt <= valid_cnt + 1;
            end
            if (parity_err)  cap_par  <= 1'b1;
            if (stop_err)    cap_stop <= 1'b1;
            if (false_start) cap_fs   <= 1'b1;
        end
    end

    task automatic clear_caps();
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bit: four cycles; when noisy only index 2 carries the true level
    task automatic send_bit(input logic lvl, input logic noisy);
        for (int k = 0; k < 4; k++) begin
            line_in = (noisy && k != 2) ? ~lvl : lvl;
            @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [31:0] d, input logic pflip,
                              input logic stop_lvl, input logic noisy);
        send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        for (int i = 0; i < 32; i++) send_bit(d[i], noisy);
        send_bit((^d) ^ pflip, noisy);
        send_bit(stop_lvl, 1'b0);
    endtask

    task automatic idle(input int n);
        line_in = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    // Vector: {data, parity flip, stop level}
    localparam logic [33:0] VEC [8] = '{
        {32'hA5A5_0F0F, 1'b0, 1'b1},
        {32'h0000_0000, 1'b0, 1'b1},
        {32'hFFFF_FFFF, 1'b0, 1'b1},
        {32'h0000_0001, 1'b0, 1'b1},
        {32'h8000_0000, 1'b0, 1'b1},
        {32'h1234_5678, 1'b1, 1'b1},
        {32'hCAFE_F00D, 1'b0, 1'b0},
        {32'h0F0F_0F0F, 1'b1, 1'b0}
    };

    // Watchdog: a hang counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_caps();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 word_valid", word_valid, 0);
        check("R1 parity_err", parity_err, 0);
        check("R1 stop_err", stop_err, 0);
        check("R1 false_start", false_start, 0);
        check("R1 chan_disabled", chan_disabled, 0);
        idle(4);

        // R4 R5 R6: table of frames, disabling off (limit 0)
        for (int v = 0; v < 8; v++) begin
            logic [31:0] d;
            logic pf, sl;
            {d, pf, sl} = VEC[v];
            clear_caps();
            send_frame(d, pf, sl, 1'b0);
            idle(12);
            check("R4 R5 R6 valid", cap_valid, (!pf && sl));
            check("R5 parity_err", cap_par, pf);
            check("R6 stop_err", cap_stop, !sl);
            if (!pf && sl) check("R4 word_data", cap_data, d);
        end
        check("R8 limit zero never disables", chan_disabled, 0);

        // R3: only the middle sample of each bit counts
        clear_caps();
        send_frame(32'h3C96_E1A7, 1'b0, 1'b1, 1'b1);
        idle(12);
        check("R3 noisy valid", cap_valid, 1);
        check("R3 noisy data", cap_data, 32'h3C96_E1A7);

        // R2: start bit too short
        clear_caps();
        line_in = 1'b0; repeat (2) @(negedge clk);
        idle(16);
        check("R2 short low false_start", cap_fs, 1);
        check("R2 short low no word", cap_valid, 0);
        // R2: second start bit drops low
        clear_caps();
        send_bit(1'b0, 1'b0);
        line_in = 1'b1; repeat (2) @(negedge clk);
        line_in = 1'b0; repeat (2) @(negedge clk);
        idle(16);
        check("R2 high phase false_start", cap_fs, 1);
        check("R2 high phase no word", cap_valid, 0);

        // R7: back-to-back frames
        clear_caps();
        send_frame(32'h1111_2222, 1'b0, 1'b1, 1'b0);
        send_frame(32'h3333_4444, 1'b0, 1'b1, 1'b0);
        idle(12);
        check("R7 two words", valid_cnt, 2);
        check("R7 last data", cap_data, 32'h3333_4444);

        // R8: limit 2, two rejects disable
        err_limit = 4'd2;
        send_frame(32'h5, 1'b1, 1'b1, 1'b0); idle(12);
        check("R8 one reject", chan_disabled, 0);
        send_frame(32'h5, 1'b1, 1'b1, 1'b0); idle(12);
        check("R8 two rejects", chan_disabled, 1);
        // R9: disabled suppresses valid, still flags errors
        clear_caps();
        send_frame(32'h77, 1'b0, 1'b1, 1'b0); idle(12);
        check("R9 valid suppressed", cap_valid, 0);
        clear_caps();
        send_frame(32'h77, 1'b1, 1'b1, 1'b0); idle(12);
        check("R9 parity flagged while disabled", cap_par, 1);
        chan_reenable = 1'b1; @(negedge clk); chan_reenable = 1'b0;
        @(negedge clk);
        check("R9 reenable clears", chan_disabled, 0);
        clear_caps();
        send_frame(32'h99, 1'b0, 1'b1, 1'b0); idle(12);
        check("R9 valid after reenable", cap_valid, 1);
        // R8: good frame clears the count
        send_frame(32'h1, 1'b1, 1'b1, 1'b0); idle(12);
        send_frame(32'h1, 1'b0, 1'b1, 1'b0); idle(12);
        send_frame(32'h1, 1'b1, 1'b1, 1'b0); idle(12);
        check("R8 good frame clears count", chan_disabled, 0);
        // R8: false start counts as a reject
        chan_reenable = 1'b1; @(negedge clk); chan_reenable = 1'b0;
        err_limit = 4'd1;
        line_in = 1'b0; @(negedge clk);
        idle(12);
        check("R8 false start disables", chan_disabled, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule